// File: doc/BRIEF.md
# External Interrupt Event Register

This block is the interrupt control and status word of a digital I/O card. One external interrupt line comes in with no timing relation to the card clock. It passes through a two-stage synchroniser, and an edge detector turns the chosen transition into a one-cycle event. Software picks which transition counts as the active one with a polarity bit. An event-tracking state machine then records the event in a pending flag. If a second event arrives before software has acknowledged the first, the machine records the overrun in a missed flag.

Software reaches the word through a simple register bus at byte offset 0x38. It sets the enable bit to arm the interrupt service. At the end of each service routine it writes ones to the two status bits to acknowledge them. The interrupt request output is high while the block is enabled and an event is pending.

The state machine holds the two status flags as four named states:
- `ST_IDLE`: nothing recorded.
- `ST_PEND`: one event is pending.
- `ST_LOST`: the pending flag has been acknowledged but an overrun is still recorded.
- `ST_OVER`: pending and overrun are both recorded.

The state machine has these named transitions:
- arm: `ST_IDLE` to `ST_PEND`, or `ST_LOST` to `ST_OVER`.
- overrun: `ST_PEND` to `ST_OVER`.
- full acknowledge: `ST_PEND` or `ST_OVER` to `ST_IDLE`.
- pending-only acknowledge: `ST_OVER` to `ST_LOST`.
- missed-only acknowledge: `ST_OVER` to `ST_PEND`, or `ST_LOST` to `ST_IDLE`.
- acknowledge-with-overrun: `ST_PEND` to `ST_LOST`, when a pending clear and a new event land in the same cycle.

Top module: `ext_irq_csr`

## Requirements
- R1: After reset, the word at offset 0x38 reads 0 and `irq_req` is low.
- R2: At offset 0x38, bit 12 (enable) and bit 6 (polarity) are read/write and take the written value at the next clock edge. Bit 17 reads the pending flag and bit 23 reads the missed flag. Every other bit reads 0.
- R3: At any offset other than 0x38, a read returns 0 and a write changes nothing.
- R4: The input passes through two synchroniser flops. With polarity 0, a 0-to-1 change of the input sets the pending bit (17) at the third rising clock edge after the change, provided enable is 1 and pending is 0.
- R5: With polarity 1, a 1-to-0 change is the active edge. A change of the polarity bit while the input is steady creates no event, and the inactive transition creates no event.
- R6: An active edge that arrives while enable is 0 and pending is 0 is ignored.
- R7: An active edge that arrives while pending is 1 sets the missed bit (23), and pending stays 1.
- R8: Writing 1 to bit 17 clears pending, and writing 1 to bit 23 clears missed. Writing 0 to either bit leaves it unchanged.
- R9: When a clearing write and an event land in the same cycle, the set wins. An edge while pending leaves missed at 1, even if the write clears bit 23. An edge that arms pending leaves pending at 1, even if the write clears bit 17.
- R10: `irq_req` is high exactly when enable and pending are both 1. After an acknowledge write of bit 17, it is low from the clock edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq_in | input | 1 | External interrupt line, asynchronous |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr_en | input | 1 | Write strobe, taken at the rising clock edge |
| bus_wr_data | input | 32 | Write data |
| bus_rd_data | output | 32 | Read data for `bus_addr`, combinational |
| irq_req | output | 1 | Interrupt request to the host |

## Verification
The assertions check four properties on every cycle:
- a written enable value appears at the next edge;
- a lone pending acknowledge empties pending;
- an edge arriving while disabled and idle leaves pending low;
- an edge arriving while pending always leaves the missed flag set, and the request drops after a pending acknowledge.

Only the bench scenarios can show the exact three-edge latency through the synchroniser. They also show that polarity flips on a steady line produce no event, that writes to other offsets are harmless, and that the set-wins outcome holds in both of its forms. The random phase compares every read and the request line against a cycle model built from the requirements.

// File: rtl/icsr_pkg.sv
package icsr_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam logic [ADDR_W-1:0] CSR_OFFSET = 8'h38;

    // bit positions decoded by driver software
    localparam int POL_BIT  = 6;
    localparam int EN_BIT   = 12;
    localparam int PEND_BIT = 17;
    localparam int MISS_BIT = 23;

    // encoding is {missed, pending}
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_PEND = 2'b01,
        ST_LOST = 2'b10,
        ST_OVER = 2'b11
    } evt_state_e;

endpackage

// File: rtl/icsr_edge_det.sv
module icsr_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    input  logic pol_low,
    output logic edge_o
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    logic lvl_now, lvl_old;

    always_comb begin
        lvl_now = sync_q[STAGES-1] ^ pol_low;
        lvl_old = prev_q ^ pol_low;
        edge_o  = lvl_now & ~lvl_old;
    end

endmodule

// File: rtl/icsr_regfile.sv
module icsr_regfile
    import icsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pend_i,
    input  logic              miss_i,
    output logic              en_o,
    output logic              pol_o,
    output logic              clr_pend_o,
    output logic              clr_miss_o,
    output logic [DATA_W-1:0] rd_data
);

    logic en_q, pol_q;
    logic hit, wr_hit;

    always_comb begin
        hit    = (addr == CSR_OFFSET);
        wr_hit = hit & wr_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            pol_q <= 1'b0;
        end else if (wr_hit) begin
            en_q  <= wr_data[EN_BIT];
            pol_q <= wr_data[POL_BIT];
        end
    end

    always_comb begin
        rd_data = '0;
        if (hit) begin
            rd_data[EN_BIT]   = en_q;
            rd_data[POL_BIT]  = pol_q;
            rd_data[PEND_BIT] = pend_i;
            rd_data[MISS_BIT] = miss_i;
        end
        en_o       = en_q;
        pol_o      = pol_q;
        clr_pend_o = wr_hit & wr_data[PEND_BIT];
        clr_miss_o = wr_hit & wr_data[MISS_BIT];
    end

    // R2
    en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (en_q == $past(wr_data[EN_BIT])));

endmodule

// File: rtl/icsr_event_fsm.sv
module icsr_event_fsm
    import icsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic edge_i,
    input  logic en_i,
    input  logic clr_pend_i,
    input  logic clr_miss_i,
    output logic pend_o,
    output logic miss_o
);

    evt_state_e state_q, state_d;
    logic       nxt_p, nxt_m, arm;

    always_comb begin
        arm   = edge_i & en_i;
        nxt_p = 1'b0;
        nxt_m = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                nxt_p = arm;
                nxt_m = 1'b0;
            end
            ST_PEND: begin
                nxt_p = ~clr_pend_i;
                nxt_m = edge_i;
            end
            ST_LOST: begin
                nxt_p = arm;
                nxt_m = ~clr_miss_i;
            end
            ST_OVER: begin
                nxt_p = ~clr_pend_i;
                nxt_m = edge_i | ~clr_miss_i;
            end
            default: begin
                nxt_p = 1'b0;
                nxt_m = 1'b0;
            end
        endcase
        state_d = evt_state_e'({nxt_m, nxt_p});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: begin pend_o = 1'b0; miss_o = 1'b0; end
            ST_PEND: begin pend_o = 1'b1; miss_o = 1'b0; end
            ST_LOST: begin pend_o = 1'b0; miss_o = 1'b1; end
            ST_OVER: begin pend_o = 1'b1; miss_o = 1'b1; end
            default: begin pend_o = 1'b0; miss_o = 1'b0; end
        endcase
    end

    // R6
    ignore_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && !en_i && !pend_o) |=> !pend_o);

    // R7
    overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && pend_o) |=> (miss_o && !$past(clr_pend_i) == pend_o));

    // R8
    ack_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pend_i && pend_o) |=> !pend_o);

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && pend_o && clr_miss_i) |=> miss_o);

endmodule

// File: rtl/ext_irq_csr.sv
module ext_irq_csr
    import icsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_irq_in,
    input  logic [7:0]        bus_addr,
    input  logic              bus_wr_en,
    input  logic [31:0]       bus_wr_data,
    output logic [31:0]       bus_rd_data,
    output logic              irq_req
);

    logic edge_w, en_w, pol_w, clr_p_w, clr_m_w, pend_w, miss_w;

    icsr_edge_det #(.STAGES(2)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_irq_in),
        .pol_low  (pol_w),
        .edge_o   (edge_w)
    );

    icsr_regfile u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (bus_addr),
        .wr_en      (bus_wr_en),
        .wr_data    (bus_wr_data),
        .pend_i     (pend_w),
        .miss_i     (miss_w),
        .en_o       (en_w),
        .pol_o      (pol_w),
        .clr_pend_o (clr_p_w),
        .clr_miss_o (clr_m_w),
        .rd_data    (bus_rd_data)
    );

    icsr_event_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_i     (edge_w),
        .en_i       (en_w),
        .clr_pend_i (clr_p_w),
        .clr_miss_i (clr_m_w),
        .pend_o     (pend_w),
        .miss_o     (miss_w)
    );

    assign irq_req = en_w & pend_w;

    // R10
    irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == CSR_OFFSET && bus_wr_data[PEND_BIT]
         && irq_req && !edge_w) |=> !irq_req);

endmodule

// File: tb/tb_ext_irq_csr.sv
module tb_ext_irq_csr;

    localparam logic [7:0] OFS = 8'h38;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_irq_in = 1'b0;
    logic [7:0]  bus_addr = OFS;
    logic        bus_wr_en = 1'b0;
    logic [31:0] bus_wr_data = '0;
    logic [31:0] bus_rd_data;
    logic        irq_req;

    int checks = 0;
    int failures = 0;

    ext_irq_csr dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_irq_in  (ext_irq_in),
        .bus_addr    (bus_addr),
        .bus_wr_en   (bus_wr_en),
        .bus_wr_data (bus_wr_data),
        .bus_rd_data (bus_rd_data),
        .irq_req     (irq_req)
    );

    always #10 clk = ~clk;   // 50 MHz

    // cycle model built from the requirements
    logic m_s1, m_s2, m_s3, m_en, m_pol, m_p, m_m;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_s3 <= 0;
            m_en <= 0; m_pol <= 0; m_p <= 0; m_m <= 0;
        end else begin
            logic ev, hit, cp, cm;
            ev  = (m_s2 ^ m_pol) & ~(m_s3 ^ m_pol);
            hit = bus_wr_en && (bus_addr == OFS);
            cp  = hit && bus_wr_data[17];
            cm  = hit && bus_wr_data[23];
            m_p <= m_p ? ~cp : (ev & m_en);
            m_m <= (ev & m_p) | (m_m & ~cm);
            if (hit) begin
                m_en  <= bus_wr_data[12];
                m_pol <= bus_wr_data[6];
            end
            m_s1 <= ext_irq_in; m_s2 <= m_s1; m_s3 <= m_s2;
        end
    end

    function automatic logic [31:0] exp_word(input logic [7:0] a);
        logic [31:0] w;
        w = '0;
        if (a == OFS) begin
            w[12] = m_en; w[6] = m_pol; w[17] = m_p; w[23] = m_m;
        end
        return w;
    endfunction

    function automatic logic exp_irq();
        return m_en & m_p;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wr_en = 1'b1; bus_wr_data = d;
        cyc();
        bus_wr_en = 1'b0; bus_addr = OFS;
    endtask

    initial begin
        #4_000_000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        cyc(2);
        rst_n = 1'b1;
        cyc();
        chk("R1 reset word", bus_rd_data, 32'h0);
        chk("R1 reset irq", {31'd0, irq_req}, 32'd0);

        wr(OFS, 32'hFFFF_FFFF);
        chk("R2 only enable/polarity stick", bus_rd_data, 32'h0000_1040);
        wr(OFS, 32'h0);
        chk("R2 cleared", bus_rd_data, 32'h0);

        wr(8'h3C, 32'h0000_1040);
        chk("R3 other write no effect", bus_rd_data, 32'h0);
        bus_addr = 8'h3C;
        #1;
        chk("R3 other offset reads 0", bus_rd_data, 32'h0);
        bus_addr = OFS;

        wr(OFS, 32'h0000_1000);
        ext_irq_in = 1'b1;
        cyc(2);
        chk("R4 not yet after two edges", bus_rd_data, 32'h0000_1000);
        cyc();
        chk("R4 pending on third edge", bus_rd_data, 32'h0002_1000);
        chk("R10 irq up", {31'd0, irq_req}, 32'd1);

        ext_irq_in = 1'b0;
        cyc(4);
        chk("R5 falling ignored at polarity 0", bus_rd_data, 32'h0002_1000);
        ext_irq_in = 1'b1;
        cyc(4);
        chk("R7 overrun sets missed", bus_rd_data, 32'h0082_1000);

        wr(OFS, 32'h0002_1000);
        chk("R8 pending cleared only", bus_rd_data, 32'h0080_1000);
        chk("R10 irq down after ack", {31'd0, irq_req}, 32'd0);
        wr(OFS, 32'h0000_1000);
        chk("R8 zero write keeps missed", bus_rd_data, 32'h0080_1000);
        wr(OFS, 32'h0080_1000);
        chk("R8 missed cleared", bus_rd_data, 32'h0000_1000);

        wr(OFS, 32'h0);
        ext_irq_in = 1'b0; cyc(4);
        ext_irq_in = 1'b1; cyc(4);
        chk("R6 edge while disabled ignored", bus_rd_data, 32'h0);

        wr(OFS, 32'h0000_1040);
        cyc(4);
        chk("R5 polarity flip on steady line no event", bus_rd_data, 32'h0000_1040);
        ext_irq_in = 1'b0;
        cyc(3);
        chk("R5 falling edge arms at polarity 1", bus_rd_data, 32'h0002_1040);

        ext_irq_in = 1'b1; cyc(4);
        ext_irq_in = 1'b0;
        cyc(2);
        wr(OFS, 32'h0082_1040);
        chk("R9 edge while pending beats missed clear", bus_rd_data, 32'h0080_1040);

        wr(OFS, 32'h0080_1040);
        ext_irq_in = 1'b1; cyc(4);
        ext_irq_in = 1'b0;
        cyc(2);
        wr(OFS, 32'h0002_1040);
        chk("R9 arming edge beats pending clear", bus_rd_data, 32'h0002_1040);
        chk("R10 irq with enable and pending", {31'd0, irq_req}, 32'd1);

        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(5) == 0) ext_irq_in = ~ext_irq_in;
            if ($urandom_range(7) == 0) begin
                bus_wr_en   = 1'b1;
                bus_addr    = ($urandom_range(4) == 0) ? 8'h30 : OFS;
                bus_wr_data = $urandom;
            end else begin
                bus_wr_en = 1'b0;
                bus_addr  = ($urandom_range(9) == 0) ? 8'h3C : OFS;
            end
            @(posedge clk);
            @(negedge clk);
            chk("R2 random read", bus_rd_data, exp_word(bus_addr));
            chk("R10 random irq", {31'd0, irq_req}, {31'd0, exp_irq()});
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule